// File: doc/BRIEF.md
# SD Command Issue Encoder

This block sits between a host register interface and the command sequencer and data-transfer engine of an SD card host controller. Software writes a 32-bit command argument as two 16-bit halves, then writes a 16-bit command word. The command word write starts the operation. The block decodes the command word into the command index, the application-command flag, the expected response kind, CRC-check and busy-wait enables, and the data-present, direction and multi-block controls. It latches these fields and the argument. It pulses a start to the sequencer and tracks the command until the response window closes. At that point it pulses response-end and, when data follows, a start for the data engine.

A separate stop register covers stop commands generated by the controller itself. Setting its bit 0 fires an immediate stop request. Its bit 8 arms an automatic stop that follows a multi-block transfer, and a multi-block command word can suppress that stop with its own bit 14. A command word with an illegal response type is rejected with a one-cycle flag. A command word written while a command is in flight is also rejected, with a different flag.

The controller is a three-state machine:
- **IDLE** waits for a command write.
- **SEND** counts the command frame length.
- **RESP** counts the expected response length.

It has four transitions:
- **IDLE→SEND** on an accepted command write.
- **SEND→IDLE** at the end of the frame for a no-response command.
- **SEND→RESP** at the end of the frame when a response is expected.
- **RESP→IDLE** at the end of the response window.

Top module: `sd_cmd_issue`

## Requirements
- R1: A write to register address 2 with a legal response type is accepted only when `cmd_busy` is low. An accepted write produces a one-cycle `cmd_start` in the following cycle, with `cmd_busy` high. From that point `cmd_index` shows command word bits 5:0 and `app_cmd` shows bit 6.
- R2: Command word bits 10:8 select the response type, which sets `rsp_kind`, `rsp_crc_chk` and `busy_wait`. The `rsp_kind` encoding is 0 = none, 1 = 48-bit, 2 = 136-bit.
  - Type 3: `rsp_kind` = 0, CRC check off.
  - Types 4 and 5: `rsp_kind` = 1, CRC check on. Only type 5 sets `busy_wait`.
  - Type 6: `rsp_kind` = 2, CRC check on.
  - Type 7: `rsp_kind` = 1, CRC check off.
- R3: Command word bit 11 drives `data_present`, bit 12 drives `data_read` (1 = card to host), and bit 13 drives `multi_blk`. All three are latched at issue.
- R4: A command write whose response type is 0, 1 or 2 produces a one-cycle `illegal_func`. It starts nothing, and `cmd_busy` stays low.
- R5: A command write while `cmd_busy` is high is dropped and produces a one-cycle `illegal_access`. The command in flight completes with unchanged fields and timing.
- R6: Writes to address 0 and address 1 load the low and high halves of the argument. `cmd_arg` takes the full argument at issue, and argument writes made while busy leave `cmd_arg` unchanged.
- R7: `rsp_end` pulses for one cycle a fixed number of cycles after `cmd_start`:
  - CMD_BITS cycles for no response;
  - CMD_BITS+SHORT_RSP_BITS cycles for a 48-bit response;
  - CMD_BITS+LONG_RSP_BITS cycles for a 136-bit response.
- R8: `cmd_busy` falls in the cycle that `rsp_end` rises. `data_start` pulses together with `rsp_end` exactly when the command carries data.
- R9: A write to address 3 with bit 0 set produces a one-cycle `stop_issue`. Bit 8 of any such write sets the automatic-stop arm when 1 and clears it when 0.
- R10: At issue, `auto_stop_en` is latched as 1 only when `multi_blk` is set, the stop arm is set, and command word bit 14 is clear.
- R11: After reset, all of these are low: `cmd_busy`, `cmd_start`, `rsp_end`, `data_start`, `stop_issue`, `illegal_func`, `illegal_access` and `auto_stop_en`. `rsp_kind` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 argument low, 1 argument high, 2 command word, 3 stop control |
| wr_data | input | 16 | Register write data |
| cmd_start | output | 1 | One-cycle start to the command sequencer |
| cmd_index | output | 6 | Latched command index |
| app_cmd | output | 1 | Latched application-command flag |
| cmd_arg | output | 32 | Latched command argument |
| rsp_kind | output | 2 | Expected response: 0 none, 1 48-bit, 2 136-bit |
| rsp_crc_chk | output | 1 | Response CRC is to be checked |
| busy_wait | output | 1 | Wait for card busy release after the response |
| data_present | output | 1 | Command has a data phase |
| data_read | output | 1 | Data flows card to host |
| multi_blk | output | 1 | Multi-block transfer |
| auto_stop_en | output | 1 | Send a stop automatically after the transfer |
| cmd_busy | output | 1 | A command is in flight |
| rsp_end | output | 1 | One-cycle command/response end |
| data_start | output | 1 | One-cycle start to the data engine |
| stop_issue | output | 1 | One-cycle immediate stop request |
| illegal_func | output | 1 | One-cycle pulse: illegal response type rejected |
| illegal_access | output | 1 | One-cycle pulse: command write while busy rejected |

## Verification
The bench builds the block with a 4-cycle command frame, a 3-cycle short response and a 6-cycle long response. These short windows let every response kind complete many times within a short run. They also make the response-end latency for each kind easy to tell apart. The 6-cycle long window leaves enough busy cycles to inject a second command write and two argument writes in the middle of a command. The effect of those writes on the command in flight is then checked at its response end.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic [5:0] index;
        logic       app;
        rsp_kind_e  kind;
        logic       crc_chk;
        logic       busy_wait;
        logic       data_present;
        logic       data_read;
        logic       multi_blk;
        logic       no_auto_stop;
        logic       legal;
    } cmd_fields_t;

    localparam logic [1:0] REG_ARG_LO = 2'd0;
    localparam logic [1:0] REG_ARG_HI = 2'd1;
    localparam logic [1:0] REG_CMD    = 2'd2;
    localparam logic [1:0] REG_STOP   = 2'd3;

endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
    import sd_cmd_pkg::*;
(
    input  logic [15:0] word,
    output cmd_fields_t fields
);
    always_comb begin
        fields              = '0;
        fields.index        = word[5:0];
        fields.app          = word[6];
        fields.data_present = word[11];
        fields.data_read    = word[12];
        fields.multi_blk    = word[13];
        fields.no_auto_stop = word[14];
        fields.kind         = RSP_NONE;
        unique case (word[10:8])
            3'd3: begin
                fields.legal = 1'b1;
                fields.kind  = RSP_NONE;
            end
            3'd4: begin
                fields.legal   = 1'b1;
                fields.kind    = RSP_SHORT;
                fields.crc_chk = 1'b1;
            end
            3'd5: begin
                fields.legal     = 1'b1;
                fields.kind      = RSP_SHORT;
                fields.crc_chk   = 1'b1;
                fields.busy_wait = 1'b1;
            end
            3'd6: begin
                fields.legal   = 1'b1;
                fields.kind    = RSP_LONG;
                fields.crc_chk = 1'b1;
            end
            3'd7: begin
                fields.legal = 1'b1;
                fields.kind  = RSP_SHORT;
            end
            default: fields.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int CMD_BITS       = 48,
    parameter int SHORT_RSP_BITS = 48,
    parameter int LONG_RSP_BITS  = 136
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  rsp_kind_e kind,
    output logic      busy,
    output logic      rsp_end
);
    localparam int MAX_A   = (CMD_BITS > SHORT_RSP_BITS) ? CMD_BITS : SHORT_RSP_BITS;
    localparam int MAX_LEN = (MAX_A > LONG_RSP_BITS) ? MAX_A : LONG_RSP_BITS;
    localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
    localparam logic [CNT_W-1:0] CMD_LOAD   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_RSP_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_RSP_BITS - 1);

    seq_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             end_now;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        end_now   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nxt_state = ST_SEND;
                    nxt_cnt   = CMD_LOAD;
                end
            end
            ST_SEND: begin
                if (cnt == '0) begin
                    if (kind == RSP_NONE) begin
                        nxt_state = ST_IDLE;
                        end_now   = 1'b1;
                    end else begin
                        nxt_state = ST_RESP;
                        nxt_cnt   = (kind == RSP_LONG) ? LONG_LOAD : SHORT_LOAD;
                    end
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_RESP: begin
                if (cnt == '0) begin
                    nxt_state = ST_IDLE;
                    end_now   = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_end <= 1'b0;
        else        rsp_end <= end_now;
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sd_stop_ctl.sv
module sd_stop_ctl #(
    parameter int DATA_W    = 16,
    parameter int FIRE_BIT  = 0,
    parameter int ARM_BIT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    output logic              armed,
    output logic              stop_issue
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            stop_issue <= 1'b0;
        end else begin
            stop_issue <= wr & data[FIRE_BIT];
            if (wr) armed <= data[ARM_BIT];
        end
    end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
    import sd_cmd_pkg::*;
#(
    parameter int CMD_BITS       = 48,
    parameter int SHORT_RSP_BITS = 48,
    parameter int LONG_RSP_BITS  = 136,
    parameter int HALF_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              cmd_start,
    output logic [5:0]        cmd_index,
    output logic              app_cmd,
    output logic [2*HALF_W-1:0] cmd_arg,
    output logic [1:0]        rsp_kind,
    output logic              rsp_crc_chk,
    output logic              busy_wait,
    output logic              data_present,
    output logic              data_read,
    output logic              multi_blk,
    output logic              auto_stop_en,
    output logic              cmd_busy,
    output logic              rsp_end,
    output logic              data_start,
    output logic              stop_issue,
    output logic              illegal_func,
    output logic              illegal_access
);
    localparam int ARG_W = 2 * HALF_W;

    cmd_fields_t       dec;
    logic [ARG_W-1:0]  arg_shadow;
    logic              cmd_wr, go, stop_armed, seq_end;
    rsp_kind_e         kind_r;

    assign cmd_wr = wr_en && (wr_addr == REG_CMD);
    assign go     = cmd_wr && !cmd_busy && dec.legal;

    sd_cmd_decode u_dec (
        .word   (wr_data),
        .fields (dec)
    );

    sd_cmd_seq #(
        .CMD_BITS       (CMD_BITS),
        .SHORT_RSP_BITS (SHORT_RSP_BITS),
        .LONG_RSP_BITS  (LONG_RSP_BITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .kind    (kind_r),
        .busy    (cmd_busy),
        .rsp_end (seq_end)
    );

    sd_stop_ctl #(.DATA_W(HALF_W)) u_stop (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_en && (wr_addr == REG_STOP)),
        .data       (wr_data),
        .armed      (stop_armed),
        .stop_issue (stop_issue)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_shadow <= '0;
        end else if (wr_en && wr_addr == REG_ARG_LO) begin
            arg_shadow[HALF_W-1:0] <= wr_data;
        end else if (wr_en && wr_addr == REG_ARG_HI) begin
            arg_shadow[ARG_W-1:HALF_W] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start      <= 1'b0;
            illegal_func   <= 1'b0;
            illegal_access <= 1'b0;
            cmd_index      <= '0;
            app_cmd        <= 1'b0;
            cmd_arg        <= '0;
            kind_r         <= RSP_NONE;
            rsp_crc_chk    <= 1'b0;
            busy_wait      <= 1'b0;
            data_present   <= 1'b0;
            data_read      <= 1'b0;
            multi_blk      <= 1'b0;
            auto_stop_en   <= 1'b0;
        end else begin
            cmd_start      <= go;
            illegal_func   <= cmd_wr && !cmd_busy && !dec.legal;
            illegal_access <= cmd_wr && cmd_busy;
            if (go) begin
                cmd_index    <= dec.index;
                app_cmd      <= dec.app;
                cmd_arg      <= arg_shadow;
                kind_r       <= dec.kind;
                rsp_crc_chk  <= dec.crc_chk;
                busy_wait    <= dec.busy_wait;
                data_present <= dec.data_present;
                data_read    <= dec.data_read;
                multi_blk    <= dec.multi_blk;
                auto_stop_en <= dec.multi_blk && stop_armed && !dec.no_auto_stop;
            end
        end
    end

    assign rsp_kind   = kind_r;
    assign rsp_end    = seq_end;
    assign data_start = seq_end && data_present;
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk #(
    parameter int ARG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             cmd_busy,
    input logic             rsp_end,
    input logic             illegal_func,
    input logic             illegal_access,
    input logic             multi_blk,
    input logic             auto_stop_en,
    input logic [ARG_W-1:0] cmd_arg
);
    a_r1_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (cmd_busy && !$past(cmd_busy)));

    a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start, illegal_func, illegal_access}));

    a_r4_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_func |-> !cmd_busy);

    a_r5_access_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_access |-> $past(cmd_busy));

    a_r6_arg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && $past(cmd_busy)) |-> $stable(cmd_arg));

    a_r8_end_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_end |-> (!cmd_busy && $past(cmd_busy)));

    a_r10_auto_needs_multi: assert property (@(posedge clk) disable iff (!rst_n)
        auto_stop_en |-> multi_blk);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk #(.ARG_W(2 * HALF_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_start      (cmd_start),
    .cmd_busy       (cmd_busy),
    .rsp_end        (rsp_end),
    .illegal_func   (illegal_func),
    .illegal_access (illegal_access),
    .multi_blk      (multi_blk),
    .auto_stop_en   (auto_stop_en),
    .cmd_arg        (cmd_arg)
);

// File: tb/sd_cmd_issue_tb.sv
`timescale 1ns/100ps
module sd_cmd_issue_tb_top;
    localparam int TB_CMD   = 4;
    localparam int TB_SHORT = 3;
    localparam int TB_LONG  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_start, app_cmd, rsp_crc_chk, busy_wait, data_present, data_read;
    logic        multi_blk, auto_stop_en, cmd_busy, rsp_end, data_start, stop_issue;
    logic        illegal_func, illegal_access;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [1:0]  rsp_kind;

    always #2.5 clk = ~clk;

    sd_cmd_issue #(
        .CMD_BITS(TB_CMD), .SHORT_RSP_BITS(TB_SHORT), .LONG_RSP_BITS(TB_LONG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_start(cmd_start), .cmd_index(cmd_index), .app_cmd(app_cmd), .cmd_arg(cmd_arg),
        .rsp_kind(rsp_kind), .rsp_crc_chk(rsp_crc_chk), .busy_wait(busy_wait),
        .data_present(data_present), .data_read(data_read), .multi_blk(multi_blk),
        .auto_stop_en(auto_stop_en), .cmd_busy(cmd_busy), .rsp_end(rsp_end),
        .data_start(data_start), .stop_issue(stop_issue), .illegal_func(illegal_func),
        .illegal_access(illegal_access)
    );

    typedef struct {
        logic [5:0]  idx;
        logic        app;
        logic [1:0]  kind;
        logic        crc, bw, dp, rd, mb, as;
        logic [31:0] arg;
        int          lat;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   t_start = 0;
    bit   armed = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (cmd_busy) @(negedge clk);
        @(negedge clk);
    endtask

    // driver: pushes the expected item, then issues the command
    task automatic issue(input logic [5:0] idx, input logic app, input logic [2:0] rt,
                         input logic dp, input logic rd, input logic mb, input logic ns,
                         input logic [31:0] arg, input bit wait_done);
        exp_t e;
        e.idx  = idx; e.app = app;
        e.kind = (rt == 3'd6) ? 2'd2 : (rt == 3'd3) ? 2'd0 : 2'd1;
        e.crc  = (rt == 3'd4) || (rt == 3'd5) || (rt == 3'd6);
        e.bw   = (rt == 3'd5);
        e.dp = dp; e.rd = rd; e.mb = mb;
        e.as   = mb && armed && !ns;
        e.arg  = arg;
        e.lat  = TB_CMD + ((e.kind == 2'd0) ? 0 : (e.kind == 2'd1) ? TB_SHORT : TB_LONG);
        wr(2'd0, arg[15:0]);
        wr(2'd1, arg[31:16]);
        q.push_back(e);
        wr(2'd2, {1'b0, ns, mb, rd, dp, rt, 1'b0, app, idx});
        if (wait_done) wait_idle();
    endtask

    // monitor: compares decoded fields at start, timing/arg/data start at end
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_start) begin
                if (q.size() == 0) chk("R1 unexpected start", 1, 0);
                else begin
                    chk("R1 index", {26'd0, cmd_index}, {26'd0, q[0].idx});
                    chk("R1 app", {31'd0, app_cmd}, {31'd0, q[0].app});
                    chk("R2 kind", {30'd0, rsp_kind}, {30'd0, q[0].kind});
                    chk("R2 crc", {31'd0, rsp_crc_chk}, {31'd0, q[0].crc});
                    chk("R2 busywait", {31'd0, busy_wait}, {31'd0, q[0].bw});
                    chk("R3 fields", {29'd0, data_present, data_read, multi_blk},
                        {29'd0, q[0].dp, q[0].rd, q[0].mb});
                    chk("R10 autostop", {31'd0, auto_stop_en}, {31'd0, q[0].as});
                    chk("R6 arg at start", cmd_arg, q[0].arg);
                    t_start = cyc;
                end
            end
            if (rsp_end) begin
                if (q.size() == 0) chk("R7 unexpected end", 1, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R7 latency", cyc - t_start, e.lat);
                    chk("R8 data_start", {31'd0, data_start}, {31'd0, e.dp});
                    chk("R8 busy low", {31'd0, cmd_busy}, 32'd0);
                    chk("R6 arg at end", cmd_arg, e.arg);
                    chk("R3 held", {29'd0, data_present, data_read, multi_blk},
                        {29'd0, e.dp, e.rd, e.mb});
                end
            end else if (data_start) begin
                chk("R8 stray data_start", 1, 0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 busy", {31'd0, cmd_busy}, 0);
        chk("R11 pulses", {26'd0, cmd_start, rsp_end, data_start, stop_issue,
                           illegal_func, illegal_access}, 0);
        chk("R11 kind/auto", {29'd0, rsp_kind, auto_stop_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(6'd17, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 1);
        issue(6'd0,  1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1);
        issue(6'd2,  1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 1);
        issue(6'd41, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 32'h40FF_8000, 1);
        issue(6'd24, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0200, 1);
        issue(6'd17, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 32'hA5A5_5A5A, 1);

        // R4: illegal response types
        for (int rt = 0; rt < 3; rt++) begin
            wr(2'd2, {5'd0, 3'(rt), 2'b00, 6'd9});
            chk("R4 illegal_func", {31'd0, illegal_func}, 1);
            chk("R4 no start", {30'd0, cmd_start, cmd_busy}, 0);
        end
        @(negedge clk);
        chk("R4 pulse width", {31'd0, illegal_func}, 0);

        // R9: immediate stop
        wr(2'd3, 16'h0001);
        chk("R9 stop_issue", {31'd0, stop_issue}, 1);
        @(negedge clk);
        chk("R9 stop pulse", {31'd0, stop_issue}, 0);

        // R10: armed auto stop
        wr(2'd3, 16'h0100); armed = 1'b1;
        chk("R9 no fire on arm", {31'd0, stop_issue}, 0);
        issue(6'd18, 1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 1);
        issue(6'd53, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_2000, 1);
        issue(6'd17, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_3000, 1);
        wr(2'd3, 16'h0000); armed = 1'b0;
        issue(6'd25, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_4000, 1);

        // R5 and R6: writes during a busy long command
        issue(6'd9, 1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0BAD_F00D, 0);
        wr(2'd2, 16'h0411);
        chk("R5 illegal_access", {31'd0, illegal_access}, 1);
        chk("R5 still busy", {31'd0, cmd_busy}, 1);
        wr(2'd0, 16'h1111);
        wr(2'd1, 16'h2222);
        chk("R6 arg unchanged while busy", cmd_arg, 32'h0BAD_F00D);
        wait_idle();
        issue(6'd13, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2222_1111, 1);

        chk("R7 queue drained", q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule